// File: doc/BRIEF.md
# Conditional Branch and Return Decision Unit

This unit sits beside an 8-bit processor's control sequencer and makes the control-flow decision for one fetched instruction. The sequencer hands it the opcode, the four condition flags (zero, carry, parity, sign), the current program counter, the 16-bit immediate operand, the HL register pair value and the return address popped from the stack. The unit then answers with four things: whether control transfers, the next program counter, any stack action the sequencer must carry out, and the cost of the instruction in machine cycles and clock states.

The decision covers eight conditional jumps, eight conditional returns, the unconditional return, the eight restart vectors, the jump through HL and the load of the stack pointer from HL. The condition is decoded from opcode bits 5:3. A restart takes its vector from the same field. The unit changes no flags. Opcodes outside this set are reported as not handled, and the caller keeps ownership of the program counter for them.

Control is a two-state machine. In `ST_IDLE` the unit shows `req_ready`. On `req_valid` (transition *accept*) it captures every input and moves to `ST_EVAL`. In `ST_EVAL` it presents `res_valid` and the result for exactly one cycle, ignores any request, and returns to `ST_IDLE` (transition *retire*).

Top module: `brdec_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and `req_ready` is 1.
- R2: A request seen with `req_ready` high is captured at that clock edge. In the following cycle `res_valid` is 1 and `req_ready` is 0. In the cycle after that, `res_valid` is 0 again. Input changes after the capture edge do not alter the result. A request held during `ST_EVAL` is not taken until the unit is back in `ST_IDLE`. While `res_valid` is 0, `taken`, `push_req`, `pop_req` and `load_sp` are 0.
- R3: The condition field is opcode bits 5:3, with this encoding: 000 zero clear, 001 zero set, 010 carry clear, 011 carry set, 100 parity clear (odd), 101 parity set (even), 110 sign clear, 111 sign set.
- R4: A conditional jump is opcode pattern 11ccc010 (for example C2, CA, E2). When the condition holds, `next_pc` is the immediate, the cost is 3 machine cycles and 10 states, and `taken` is 1. Otherwise `next_pc` is the PC plus 3, the cost is 2 and 7, and `taken` is 0.
- R5: A conditional return is opcode pattern 11ccc000 (C0 through F8). When the condition holds, `next_pc` is the popped address, `pop_req` is 1 and the cost is 3 and 12. Otherwise `next_pc` is the PC plus 1, `pop_req` is 0 and the cost is 1 and 6.
- R6: Opcode C9 always transfers to the popped address, with `pop_req` set and a cost of 3 and 10.
- R7: A restart is opcode pattern 11nnn111. It always transfers to nnn times 8, zero-extended. It sets `push_req` and costs 3 and 12.
- R8: Opcode E9 transfers to the HL value (H to the upper byte, L to the lower byte) at a cost of 1 and 6.
- R9: Opcode F9 does not transfer. It sets `load_sp` with `sp_value` equal to HL, gives `next_pc` as the PC plus 1, and costs 1 and 6.
- R10: Any other opcode sets `not_handled`. It leaves `next_pc` equal to the current PC, holds `taken`, `push_req`, `pop_req` and `load_sp` at 0, and reports a cost of 0 and 0.
- R11: PC-plus-length arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit is idle and can capture a request |
| opcode | input | 8 | Fetched opcode |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_parity | input | 1 | Parity flag (1 = even) |
| flag_sign | input | 1 | Sign flag |
| cur_pc | input | ADDR_W | PC of the instruction |
| imm_addr | input | ADDR_W | Immediate operand of a jump |
| hl_val | input | ADDR_W | HL register pair |
| ret_addr | input | ADDR_W | Address popped from the stack |
| res_valid | output | 1 | Result valid (one cycle) |
| taken | output | 1 | Control transfers |
| next_pc | output | ADDR_W | Next program counter |
| push_req | output | 1 | Push return address (restart) |
| pop_req | output | 1 | Pop return address (return taken) |
| load_sp | output | 1 | Load stack pointer from `sp_value` |
| sp_value | output | ADDR_W | New stack pointer value |
| not_handled | output | 1 | Opcode outside this unit's set |
| mcycles | output | 3 | Machine cycles of the instruction |
| tstates | output | 5 | Clock states of the instruction |

## Verification
The bench builds the unit with ADDR_W at its default of 16, so that the immediate, HL and return values match the real address width. This also lets a PC near FFFF wrap to a small value when 1 or 3 is added. Every one of the eight condition codes is driven both met and unmet, for jumps and for returns. Beside those directed cases, the bench uses random opcodes and operands. These hit the fixed-function opcodes and many unhandled ones, with the bench mixing fresh inputs after each capture to show that the result comes from the captured values.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1
    } brdec_state_e;

    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_JCC  = 3'd1,
        CLS_RCC  = 3'd2,
        CLS_RET  = 3'd3,
        CLS_RST  = 3'd4,
        CLS_PCHL = 3'd5,
        CLS_SPHL = 3'd6
    } op_class_e;

    localparam int MC_W = 3;
    localparam int TS_W = 5;

    // condition field codes, opcode bits 5:3
    localparam logic [2:0] CC_NZ = 3'd0;
    localparam logic [2:0] CC_Z  = 3'd1;
    localparam logic [2:0] CC_NC = 3'd2;
    localparam logic [2:0] CC_C  = 3'd3;
    localparam logic [2:0] CC_PO = 3'd4;
    localparam logic [2:0] CC_PE = 3'd5;
    localparam logic [2:0] CC_P  = 3'd6;
    localparam logic [2:0] CC_M  = 3'd7;

endpackage

// File: rtl/brdec_classify.sv
module brdec_classify
    import brdec_pkg::*;
(
    input  logic [7:0]  op,
    output op_class_e   cls,
    output logic [2:0]  field
);
    assign field = op[5:3];

    always_comb begin
        casez (op)
            8'b11??_?010: cls = CLS_JCC;
            8'b11??_?000: cls = CLS_RCC;
            8'b11??_?111: cls = CLS_RST;
            8'hC9:        cls = CLS_RET;
            8'hE9:        cls = CLS_PCHL;
            8'hF9:        cls = CLS_SPHL;
            default:      cls = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/brdec_cond.sv
module brdec_cond
    import brdec_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       fz,
    input  logic       fc,
    input  logic       fp,
    input  logic       fs,
    output logic       met
);
    always_comb begin
        unique case (sel)
            CC_NZ:   met = !fz;
            CC_Z:    met =  fz;
            CC_NC:   met = !fc;
            CC_C:    met =  fc;
            CC_PO:   met = !fp;
            CC_PE:   met =  fp;
            CC_P:    met = !fs;
            CC_M:    met =  fs;
            default: met = 1'b0;
        endcase
    end
endmodule

// File: rtl/brdec_cost.sv
module brdec_cost
    import brdec_pkg::*;
(
    input  op_class_e         cls,
    input  logic              met,
    output logic [MC_W-1:0]   mc,
    output logic [TS_W-1:0]   ts
);
    always_comb begin
        mc = '0;
        ts = '0;
        unique case (cls)
            CLS_JCC: begin
                mc = met ? MC_W'(3) : MC_W'(2);
                ts = met ? TS_W'(10) : TS_W'(7);
            end
            CLS_RCC: begin
                mc = met ? MC_W'(3) : MC_W'(1);
                ts = met ? TS_W'(12) : TS_W'(6);
            end
            CLS_RET: begin
                mc = MC_W'(3);
                ts = TS_W'(10);
            end
            CLS_RST: begin
                mc = MC_W'(3);
                ts = TS_W'(12);
            end
            CLS_PCHL, CLS_SPHL: begin
                mc = MC_W'(1);
                ts = TS_W'(6);
            end
            default: begin
                mc = '0;
                ts = '0;
            end
        endcase
    end
endmodule

// File: rtl/brdec_target.sv
module brdec_target
    import brdec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  op_class_e           cls,
    input  logic                met,
    input  logic [2:0]          field,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [ADDR_W-1:0]   imm,
    input  logic [ADDR_W-1:0]   hl,
    input  logic [ADDR_W-1:0]   ret,
    output logic                xfer,
    output logic [ADDR_W-1:0]   target,
    output logic                push,
    output logic                pop,
    output logic                sp_load,
    output logic                unknown
);
    localparam int VEC_SHIFT = 3;
    localparam int VEC_PAD   = ADDR_W - 3 - VEC_SHIFT;

    logic [ADDR_W-1:0] pc_plus1;
    logic [ADDR_W-1:0] pc_plus3;
    logic [ADDR_W-1:0] vector;

    assign pc_plus1 = pc + ADDR_W'(1);
    assign pc_plus3 = pc + ADDR_W'(3);
    assign vector   = {{VEC_PAD{1'b0}}, field, {VEC_SHIFT{1'b0}}};

    always_comb begin
        xfer    = 1'b0;
        target  = pc;
        push    = 1'b0;
        pop     = 1'b0;
        sp_load = 1'b0;
        unknown = 1'b0;
        unique case (cls)
            CLS_JCC: begin
                xfer   = met;
                target = met ? imm : pc_plus3;
            end
            CLS_RCC: begin
                xfer   = met;
                pop    = met;
                target = met ? ret : pc_plus1;
            end
            CLS_RET: begin
                xfer   = 1'b1;
                pop    = 1'b1;
                target = ret;
            end
            CLS_RST: begin
                xfer   = 1'b1;
                push   = 1'b1;
                target = vector;
            end
            CLS_PCHL: begin
                xfer   = 1'b1;
                target = hl;
            end
            CLS_SPHL: begin
                sp_load = 1'b1;
                target  = pc_plus1;
            end
            default: begin
                unknown = 1'b1;
                target  = pc;
            end
        endcase
    end
endmodule

// File: rtl/brdec_unit.sv
module brdec_unit
    import brdec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [7:0]         opcode,
    input  logic               flag_zero,
    input  logic               flag_carry,
    input  logic               flag_parity,
    input  logic               flag_sign,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic [ADDR_W-1:0]  imm_addr,
    input  logic [ADDR_W-1:0]  hl_val,
    input  logic [ADDR_W-1:0]  ret_addr,
    output logic               res_valid,
    output logic               taken,
    output logic [ADDR_W-1:0]  next_pc,
    output logic               push_req,
    output logic               pop_req,
    output logic               load_sp,
    output logic [ADDR_W-1:0]  sp_value,
    output logic               not_handled,
    output logic [2:0]         mcycles,
    output logic [4:0]         tstates
);
    brdec_state_e state_q, state_d;

    logic [7:0]        op_q;
    logic              fz_q, fc_q, fp_q, fs_q;
    logic [ADDR_W-1:0] pc_q, imm_q, hl_q, ret_q;
    logic              accept;

    op_class_e         cls;
    logic [2:0]        field;
    logic              met;
    logic              xfer, push, pop, sp_load, unknown;
    logic [ADDR_W-1:0] target;
    logic [MC_W-1:0]   mc;
    logic [TS_W-1:0]   ts;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: accept and retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            fz_q  <= 1'b0;
            fc_q  <= 1'b0;
            fp_q  <= 1'b0;
            fs_q  <= 1'b0;
            pc_q  <= '0;
            imm_q <= '0;
            hl_q  <= '0;
            ret_q <= '0;
        end else if (accept) begin
            op_q  <= opcode;
            fz_q  <= flag_zero;
            fc_q  <= flag_carry;
            fp_q  <= flag_parity;
            fs_q  <= flag_sign;
            pc_q  <= cur_pc;
            imm_q <= imm_addr;
            hl_q  <= hl_val;
            ret_q <= ret_addr;
        end
    end

    brdec_classify u_classify (
        .op    (op_q),
        .cls   (cls),
        .field (field)
    );

    brdec_cond u_cond (
        .sel (field),
        .fz  (fz_q),
        .fc  (fc_q),
        .fp  (fp_q),
        .fs  (fs_q),
        .met (met)
    );

    brdec_target #(.ADDR_W(ADDR_W)) u_target (
        .cls     (cls),
        .met     (met),
        .field   (field),
        .pc      (pc_q),
        .imm     (imm_q),
        .hl      (hl_q),
        .ret     (ret_q),
        .xfer    (xfer),
        .target  (target),
        .push    (push),
        .pop     (pop),
        .sp_load (sp_load),
        .unknown (unknown)
    );

    brdec_cost u_cost (
        .cls (cls),
        .met (met),
        .mc  (mc),
        .ts  (ts)
    );

    // output process
    always_comb begin
        req_ready   = 1'b0;
        res_valid   = 1'b0;
        taken       = 1'b0;
        next_pc     = '0;
        push_req    = 1'b0;
        pop_req     = 1'b0;
        load_sp     = 1'b0;
        sp_value    = '0;
        not_handled = 1'b0;
        mcycles     = '0;
        tstates     = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_EVAL: begin
                res_valid   = 1'b1;
                taken       = xfer;
                next_pc     = target;
                push_req    = push;
                pop_req     = pop;
                load_sp     = sp_load;
                sp_value    = sp_load ? hl_q : '0;
                not_handled = unknown;
                mcycles     = mc;
                tstates     = ts;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/brdec_unit_chk.sv
module brdec_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              res_valid,
    input logic              taken,
    input logic [ADDR_W-1:0] next_pc,
    input logic              push_req,
    input logic              pop_req,
    input logic              load_sp,
    input logic              not_handled,
    input logic [2:0]        mcycles,
    input logic [4:0]        tstates
);
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R2

    AST_ACCEPT_THEN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid); // R2

    AST_NO_READY_IN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(taken || push_req || pop_req || load_sp)); // R2

    AST_UNHANDLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && not_handled) |-> !(taken || push_req || pop_req || load_sp)
                                       && mcycles == 3'd0 && tstates == 5'd0); // R10

    AST_PUSH_IS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && push_req) |-> taken && next_pc[2:0] == 3'd0
                                    && mcycles == 3'd3 && tstates == 5'd12); // R7

    AST_POP_COSTS_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && pop_req) |-> taken && mcycles == 3'd3); // R5

    AST_SPLOAD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && load_sp) |-> !taken && tstates == 5'd6); // R9
endmodule

bind brdec_unit brdec_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/brdec_unit_tb.sv
`timescale 1ns/1ps
module brdec_unit_tb;
    localparam int AW = 16;

    typedef struct packed {
        logic          tk;
        logic [AW-1:0] npc;
        logic          push;
        logic          pop;
        logic          lsp;
        logic [AW-1:0] sp;
        logic          nh;
        logic [2:0]    mc;
        logic [4:0]    ts;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] opcode = '0;
    logic fz = 0, fc = 0, fp = 0, fs = 0;
    logic [AW-1:0] cur_pc = '0, imm_addr = '0, hl_val = '0, ret_addr = '0;
    logic req_ready, res_valid, taken, push_req, pop_req, load_sp, not_handled;
    logic [AW-1:0] next_pc, sp_value;
    logic [2:0] mcycles;
    logic [4:0] tstates;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    brdec_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .opcode(opcode), .flag_zero(fz), .flag_carry(fc), .flag_parity(fp),
        .flag_sign(fs), .cur_pc(cur_pc), .imm_addr(imm_addr), .hl_val(hl_val),
        .ret_addr(ret_addr), .res_valid(res_valid), .taken(taken),
        .next_pc(next_pc), .push_req(push_req), .pop_req(pop_req),
        .load_sp(load_sp), .sp_value(sp_value), .not_handled(not_handled),
        .mcycles(mcycles), .tstates(tstates)
    );

    function automatic bit cond_ok(input logic [2:0] cc, input logic z, c, p, s);
        case (cc)
            3'd0: return !z;  3'd1: return z;
            3'd2: return !c;  3'd3: return c;
            3'd4: return !p;  3'd5: return p;
            3'd6: return !s;  default: return s;
        endcase
    endfunction

    function automatic exp_t model(input logic [7:0] op, input logic z, c, p, s,
                                   input logic [AW-1:0] pc, imm, hl, ra);
        exp_t e;
        bit m;
        e = '0;
        m = cond_ok(op[5:3], z, c, p, s);
        if (op[7:6] == 2'b11 && op[2:0] == 3'b010) begin         // R4
            e.tk = m; e.npc = m ? imm : pc + 16'd3;
            e.mc = m ? 3'd3 : 3'd2; e.ts = m ? 5'd10 : 5'd7;
        end else if (op[7:6] == 2'b11 && op[2:0] == 3'b000) begin // R5
            e.tk = m; e.pop = m; e.npc = m ? ra : pc + 16'd1;
            e.mc = m ? 3'd3 : 3'd1; e.ts = m ? 5'd12 : 5'd6;
        end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin // R7
            e.tk = 1; e.push = 1; e.npc = {10'd0, op[5:3], 3'd0};
            e.mc = 3'd3; e.ts = 5'd12;
        end else if (op == 8'hC9) begin                           // R6
            e.tk = 1; e.pop = 1; e.npc = ra; e.mc = 3'd3; e.ts = 5'd10;
        end else if (op == 8'hE9) begin                           // R8
            e.tk = 1; e.npc = hl; e.mc = 3'd1; e.ts = 5'd6;
        end else if (op == 8'hF9) begin                           // R9
            e.lsp = 1; e.sp = hl; e.npc = pc + 16'd1; e.mc = 3'd1; e.ts = 5'd6;
        end else begin                                            // R10
            e.nh = 1; e.npc = pc;
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        if (op[7:6] == 2'b11 && op[2:0] == 3'b010) return "R4";
        if (op[7:6] == 2'b11 && op[2:0] == 3'b000) return "R5";
        if (op[7:6] == 2'b11 && op[2:0] == 3'b111) return "R7";
        if (op == 8'hC9) return "R6";
        if (op == 8'hE9) return "R8";
        if (op == 8'hF9) return "R9";
        return "R10";
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag, input exp_t e);
        exp_t a;
        a = {taken, next_pc, push_req, pop_req, load_sp, sp_value, not_handled, mcycles, tstates};
        chk(tag, "result", a, e);
    endtask

    // one full request; inputs scrambled after capture (R2)
    task automatic run(input logic [7:0] op, input logic z, c, p, s,
                       input logic [AW-1:0] pc, imm, hl, ra, input string extra);
        exp_t e;
        e = model(op, z, c, p, s, pc, imm, hl, ra);
        @(negedge clk);
        req_valid = 1; opcode = op; fz = z; fc = c; fp = p; fs = s;
        cur_pc = pc; imm_addr = imm; hl_val = hl; ret_addr = ra;
        @(negedge clk);
        req_valid = 0; opcode = ~op; fz = ~z; fc = ~c; fp = ~p; fs = ~s;
        cur_pc = ~pc; imm_addr = ~imm; hl_val = ~hl; ret_addr = ~ra;
        #1;
        chk("R2", "res_valid", res_valid, 1);
        chk("R2", "req_ready", req_ready, 0);
        compare(extra.len() > 0 ? extra : tag_of(op), e);
        @(negedge clk);
        #1;
        chk("R2", "res_valid drop", res_valid, 0);
        chk("R2", "taken idle", taken, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        #1;
        chk("R1", "res_valid", res_valid, 0);
        chk("R1", "req_ready", req_ready, 1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "res_valid after", res_valid, 0);
        chk("R1", "req_ready after", req_ready, 1);

        // R3: every condition code, met and unmet, for jumps and returns
        for (int cc = 0; cc < 8; cc++) begin
            for (int v = 0; v < 2; v++) begin
                logic b;
                b = v[0];
                run({2'b11, cc[2:0], 3'b010}, b, b, b, b, 16'h1000, 16'hABCD, 16'h2222, 16'h3333, "R3");
                run({2'b11, cc[2:0], 3'b000}, b, b, b, b, 16'h1000, 16'hABCD, 16'h2222, 16'h3333, "R3");
            end
        end
        run(8'hCA, 1, 0, 0, 0, 16'h0100, 16'h4567, 0, 0, "R4");
        run(8'hC2, 1, 0, 0, 0, 16'h0100, 16'h4567, 0, 0, "R4");
        run(8'hE2, 0, 0, 1, 0, 16'h0100, 16'h4567, 0, 0, "R4");
        run(8'hC9, 0, 0, 0, 0, 16'h0200, 0, 0, 16'h8001, "R6");
        for (int n = 0; n < 8; n++)
            run({2'b11, n[2:0], 3'b111}, 0, 0, 0, 0, 16'h7777, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R7");
        run(8'hE9, 0, 0, 0, 0, 16'h0300, 0, 16'hBEEF, 0, "R8");
        run(8'hF9, 0, 0, 0, 0, 16'h0300, 0, 16'hC0DE, 0, "R9");
        run(8'h00, 1, 1, 1, 1, 16'h0400, 16'h1111, 16'h2222, 16'h3333, "R10");
        run(8'h3A, 0, 0, 0, 0, 16'h0401, 16'h1111, 16'h2222, 16'h3333, "R10");
        // R11: wrap of PC plus length
        run(8'hCA, 0, 0, 0, 0, 16'hFFFE, 16'h1234, 0, 0, "R11");
        run(8'hC8, 0, 0, 0, 0, 16'hFFFF, 0, 0, 16'h5555, "R11");
        run(8'hF9, 0, 0, 0, 0, 16'hFFFF, 0, 16'h0042, 0, "R11");

        // R2: request held during ST_EVAL is not taken there
        @(negedge clk);
        req_valid = 1; opcode = 8'hE9; hl_val = 16'h1357; cur_pc = 16'h0010;
        @(negedge clk);
        opcode = 8'hC9; ret_addr = 16'h2468;
        #1;
        chk("R2", "first result", next_pc, 16'h1357);
        @(negedge clk);
        #1;
        chk("R2", "held request ignored in eval", res_valid, 0);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R2", "held request served", res_valid, 1);
        chk("R2", "held request target", next_pc, 16'h2468);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            logic [3:0] f;
            case ($urandom % 4)
                0: op = {2'b11, 3'($urandom), 3'b010};
                1: op = {2'b11, 3'($urandom), 3'b000};
                2: op = {2'b11, 3'($urandom), 3'b111};
                default: op = 8'($urandom);
            endcase
            f = 4'($urandom);
            run(op, f[0], f[1], f[2], f[3], 16'($urandom), 16'($urandom),
                16'($urandom), 16'($urandom), "");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule